// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Detection and Event Flags

This block receives asynchronous serial characters of one start bit, eight data bits sent least significant bit first, and one stop bit. The line is sampled on a 16x oversampling strobe supplied from outside. Good characters go to a receive buffer interface, which counts characters into the current buffer and closes the buffer when a programmed count is reached or when an explicit close strobe arrives. When the buffer side reports that it has no space, characters are discarded without being delivered.

The block keeps an 8-bit event register and an 8-bit mask register behind a small read/write bus. The events are: break received, break ended, character discarded (busy), receive buffer closed, and transmit done, which is taken from an external pulse. Software clears an event by writing a one to its bit. The interrupt output is high while any event bit is set and its mask bit is also set. A line held low is reported once as a break, however long it lasts. The end of a break is reported only after the line has been high for one full bit time.

Top module: `uart_rx_evt`

## Requirements
- R1: Register bits are numbered with bit 0 as the most significant bit, so field n is vector bit 7-n. Field 1 is break end (0x40), field 3 is break received (0x10), field 5 is busy (0x04), field 6 is transmit done (0x02) and field 7 is receive buffer closed (0x01). Fields 0, 2 and 4 always read zero, in both registers. `reg_sel` = 0 selects the event register and `reg_sel` = 1 selects the mask register.
- R2: Writing a one to an event bit clears it, and writing a zero leaves it unchanged. If hardware sets a bit in the same cycle as a clear of that bit, the bit stays set.
- R3: `irq` is high exactly while some event bit and its mask bit are both one. A mask write stores the written value, limited to the implemented fields.
- R4: After reset, both registers read zero and `irq` is low.
- R5: A frame is a start bit, eight data bits (LSB first) and a stop bit, each lasting 16 `tick` strobes. A start bit is confirmed at its middle. A frame with a high stop bit is delivered as a one-cycle `rx_valid` pulse with `rx_data`.
- R6: A frame whose start, data and stop samples are all low sets break received once, is not delivered, and does not set break received again while the line stays low.
- R7: After a break, break end is set only once the line has been sampled high on 16 consecutive ticks. A shorter high period does not set it.
- R8: A good frame that arrives while `buf_ready` is low is dropped without an `rx_valid` pulse. Busy is set for the first dropped frame only, and is set again only after `buf_ready` has been high. Delivery resumes once `buf_ready` is high.
- R9: The receive buffer closes, setting the receive event, when the delivered count reaches a nonzero `max_cnt`, or when `buf_close` pulses while the buffer holds at least one character. A close of an empty buffer has no effect. Closing resets the count.
- R10: A one-cycle `tx_done` pulse sets the transmit done event.
- R11: A frame with a low stop bit and nonzero data is discarded. It sets no event and is not delivered, and reception restarts once the line returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 16x oversampling strobe |
| rxd | input | 1 | Serial receive line, idle high |
| buf_ready | input | 1 | Receive buffer has space |
| buf_close | input | 1 | Request to close the current buffer |
| max_cnt | input | 8 | Characters per buffer; 0 means close only by strobe |
| rx_valid | output | 1 | Delivered character strobe |
| rx_data | output | 8 | Delivered character |
| tx_done | input | 1 | Transmit done pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the event register, 1 selects the mask register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rxd` is stable enough for the two-flop synchronizer to follow bit-level changes, that `tick` pulses at most every other clock, and that register writes and `tx_done` are single-cycle pulses. The bench drives the line on the falling edge. It holds every bit for exactly 16 ticks with a tick on alternate clocks, and keeps write, close and transmit strobes one clock wide. Random bytes never equal zero, so a break frame appears only where the bench intends one.

// File: rtl/uart_rx_evt_pkg.sv
package uart_rx_evt_pkg;
  localparam int EV_W       = 8;
  // vector positions; field n of the register map is vector bit (7 - n)
  localparam int EV_RX      = 0;
  localparam int EV_TX      = 1;
  localparam int EV_BUSY    = 2;
  localparam int EV_BRK     = 4;
  localparam int EV_BRK_END = 6;
  localparam logic [EV_W-1:0] EV_IMPL = 8'h57;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BRK,
    RX_RESYNC
  } rx_state_e;
endpackage

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_evt_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  output logic          line_o,
  output logic          char_ok_o,
  output logic [DW-1:0] char_data_o,
  output logic          brk_o,
  output logic          brk_end_o
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] MID_C  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);
  localparam logic [BW-1:0] LASTB  = BW'(DW - 1);

  logic [1:0]    sync_q;
  rx_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] hi_q, hi_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] shift_q, shift_d;
  logic          ok_q, ok_d, brk_q, brk_d, bend_q, bend_d;
  logic          line;

  assign line = sync_q[1];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    hi_d    = hi_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    ok_d    = 1'b0;
    brk_d   = 1'b0;
    bend_d  = 1'b0;
    if (tick) begin
      unique case (state_q)
        RX_IDLE: begin
          if (!line) begin
            state_d = RX_START;
            cnt_d   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == MID_C) begin
            cnt_d   = '0;
            bit_d   = '0;
            state_d = line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == LAST_C) begin
            cnt_d   = '0;
            shift_d = {line, shift_q[DW-1:1]};
            if (bit_q == LASTB) state_d = RX_STOP;
            else                bit_d   = bit_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == LAST_C) begin
            cnt_d = '0;
            if (line) begin
              ok_d    = 1'b1;
              state_d = RX_IDLE;
            end else if (shift_q == '0) begin
              brk_d   = 1'b1;
              hi_d    = '0;
              state_d = RX_BRK;
            end else begin
              state_d = RX_RESYNC;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_BRK: begin
          if (!line) begin
            hi_d = '0;
          end else if (hi_q == LAST_C) begin
            bend_d  = 1'b1;
            state_d = RX_IDLE;
          end else begin
            hi_d = hi_q + 1'b1;
          end
        end
        RX_RESYNC: begin
          if (line) state_d = RX_IDLE;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      hi_q    <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      ok_q    <= 1'b0;
      brk_q   <= 1'b0;
      bend_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      ok_q   <= ok_d;
      brk_q  <= brk_d;
      bend_q <= bend_d;
      if (tick) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
        hi_q    <= hi_d;
        bit_q   <= bit_d;
        shift_q <= shift_d;
      end
    end
  end

  assign line_o      = line;
  assign char_ok_o   = ok_q;
  assign char_data_o = shift_q;
  assign brk_o       = brk_q;
  assign brk_end_o   = bend_q;
endmodule

// File: rtl/uart_rx_bufctl.sv
module uart_rx_bufctl #(
  parameter int DW   = 8,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            char_ok,
  input  logic [DW-1:0]   char_data,
  input  logic            buf_ready,
  input  logic            close_req,
  input  logic [CNTW-1:0] max_cnt,
  output logic            rx_valid_o,
  output logic [DW-1:0]   rx_data_o,
  output logic            rx_set_o,
  output logic            busy_set_o
);
  logic [CNTW-1:0] fill_q, fill_d;
  logic [CNTW:0]   fill_inc;
  logic            drop_q, drop_d;
  logic            valid_q, rxs_q, busy_q;
  logic [DW-1:0]   data_q;
  logic            accept, drop, hit_max, close;

  always_comb begin
    accept   = char_ok & buf_ready;
    drop     = char_ok & ~buf_ready;
    fill_inc = {1'b0, fill_q} + (CNTW + 1)'(accept);
    hit_max  = accept && (max_cnt != '0) && (fill_inc >= {1'b0, max_cnt});
    close    = hit_max || (close_req && (fill_inc != '0));
    if (close)               fill_d = '0;
    else if (fill_inc[CNTW]) fill_d = fill_q;
    else                     fill_d = fill_inc[CNTW-1:0];
    if (buf_ready) drop_d = 1'b0;
    else           drop_d = drop_q | drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      drop_q  <= 1'b0;
      valid_q <= 1'b0;
      rxs_q   <= 1'b0;
      busy_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      fill_q  <= fill_d;
      drop_q  <= drop_d;
      valid_q <= accept;
      rxs_q   <= close;
      busy_q  <= drop & ~drop_q;
      if (accept) data_q <= char_data;
    end
  end

  assign rx_valid_o = valid_q;
  assign rx_data_o  = data_q;
  assign rx_set_o   = rxs_q;
  assign busy_set_o = busy_q;
endmodule

// File: rtl/uart_rx_evtreg.sv
module uart_rx_evtreg
  import uart_rx_evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] hw_set,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [EV_W-1:0] reg_wdata,
  output logic [EV_W-1:0] reg_rdata,
  output logic            irq,
  output logic [EV_W-1:0] evt_o,
  output logic [EV_W-1:0] mask_o
);
  logic [EV_W-1:0] evt_q, evt_d, mask_q, mask_d, clr;
  logic            mask_we;

  always_comb begin
    clr     = (reg_wr && !reg_sel) ? reg_wdata : '0;
    evt_d   = ((evt_q & ~clr) | hw_set) & EV_IMPL;
    mask_we = reg_wr & reg_sel;
    mask_d  = reg_wdata & EV_IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q <= evt_d;
      if (mask_we) mask_q <= mask_d;
    end
  end

  assign reg_rdata = reg_sel ? mask_q : evt_q;
  assign irq       = |(evt_q & mask_q);
  assign evt_o     = evt_q;
  assign mask_o    = mask_q;
endmodule

// File: rtl/uart_rx_evt.sv
module uart_rx_evt
  import uart_rx_evt_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int DW   = 8,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rxd,
  input  logic            buf_ready,
  input  logic            buf_close,
  input  logic [CNTW-1:0] max_cnt,
  output logic            rx_valid,
  output logic [DW-1:0]   rx_data,
  input  logic            tx_done,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [EV_W-1:0] reg_wdata,
  output logic [EV_W-1:0] reg_rdata,
  output logic            irq
);
  logic [1:0]      rst_pipe_q;
  logic            rst_n_i;
  logic            line_s, char_ok, brk_set, brk_end_set, rx_set, busy_set;
  logic [DW-1:0]   char_data;
  logic [EV_W-1:0] hw_set, evt_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  uart_rx_core #(.OSR(OSR), .DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n_i), .tick(tick), .rxd(rxd),
    .line_o(line_s), .char_ok_o(char_ok), .char_data_o(char_data),
    .brk_o(brk_set), .brk_end_o(brk_end_set)
  );

  uart_rx_bufctl #(.DW(DW), .CNTW(CNTW)) u_buf (
    .clk(clk), .rst_n(rst_n_i), .char_ok(char_ok), .char_data(char_data),
    .buf_ready(buf_ready), .close_req(buf_close), .max_cnt(max_cnt),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_set_o(rx_set), .busy_set_o(busy_set)
  );

  always_comb begin
    hw_set             = '0;
    hw_set[EV_RX]      = rx_set;
    hw_set[EV_TX]      = tx_done;
    hw_set[EV_BUSY]    = busy_set;
    hw_set[EV_BRK]     = brk_set;
    hw_set[EV_BRK_END] = brk_end_set;
  end

  uart_rx_evtreg u_regs (
    .clk(clk), .rst_n(rst_n_i), .hw_set(hw_set),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .evt_o(evt_q), .mask_o(mask_q)
  );
endmodule

// File: rtl/uart_rx_evt_chk.sv
module uart_rx_evt_chk
  import uart_rx_evt_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic            reg_sel,
  input logic [EV_W-1:0] reg_wdata,
  input logic [EV_W-1:0] reg_rdata,
  input logic            irq,
  input logic            rx_valid,
  input logic            buf_ready,
  input logic [EV_W-1:0] evt,
  input logic            line_s,
  input logic            brk_set,
  input logic            brk_end_set,
  input logic            char_ok
);
  logic [EV_W-1:0] clr_req;
  assign clr_req = (reg_wr && !reg_sel) ? reg_wdata : '0;

  p_resv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~EV_IMPL) == '0);

  p_w1c_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt) & ~evt & ~$past(clr_req)) == '0));

  p_irq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq) && !$past(reg_wr)) |-> irq);

  p_brk_no_deliver_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_set |-> !char_ok);

  p_brk_end_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_end_set |-> $past(line_s));

  p_drop_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(buf_ready));
endmodule

bind uart_rx_evt uart_rx_evt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
  .rx_valid(rx_valid), .buf_ready(buf_ready), .evt(evt_q),
  .line_s(line_s), .brk_set(brk_set), .brk_end_set(brk_end_set),
  .char_ok(char_ok)
);

// File: tb/uart_rx_evt_tb.sv
module uart_rx_evt_tb;
  logic       clk, rst_n, tick, rxd, buf_ready, buf_close, tx_done;
  logic       reg_wr, reg_sel, rx_valid, irq;
  logic [7:0] max_cnt, rx_data, reg_wdata, reg_rdata;
  int         n_chk, n_fail, got_cnt;
  logic [7:0] got_data;
  bit         done;

  uart_rx_evt u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .buf_ready(buf_ready),
    .buf_close(buf_close), .max_cnt(max_cnt), .rx_valid(rx_valid),
    .rx_data(rx_data), .tx_done(tx_done), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(negedge clk) tick <= ~tick;
  always @(negedge clk) if (rx_valid) begin got_cnt++; got_data = rx_data; end

  // field n of the register map sits at vector bit 7-n
  function automatic logic [7:0] fld(input int n);
    return 8'h80 >> n;
  endfunction
  function automatic logic [7:0] impl_bits();
    return fld(1) | fld(3) | fld(5) | fld(6) | fld(7);
  endfunction
  function automatic bit closes(input int fill, input int maxc);
    return (maxc != 0) && (fill >= maxc);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask
  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask
  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic s, output logic [7:0] v);
    @(negedge clk); reg_sel = s; #1 v = reg_rdata;
  endtask
  task automatic frame(input logic [7:0] d, input logic stop);
    rxd = 0; clocks(32);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; clocks(32); end
    rxd = stop; clocks(32);
  endtask
  task automatic good(input logic [7:0] d);
    frame(d, 1'b1); rxd = 1; clocks(64);
  endtask
  task automatic close_pulse();
    @(negedge clk); buf_close = 1; @(negedge clk); buf_close = 0; clocks(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [7:0] v, d;
    int fill, maxc, base;
    void'($urandom(32'd2718));
    n_chk = 0; n_fail = 0; got_cnt = 0; done = 0; tick = 0;
    rst_n = 0; rxd = 1; buf_ready = 1; buf_close = 0; tx_done = 0;
    reg_wr = 0; reg_sel = 0; reg_wdata = 0; max_cnt = 8'd3;
    clocks(4); rst_n = 1; clocks(6);

    rd(0, v); check("R4 event reset", v, 0);
    rd(1, v); check("R4 mask reset", v, 0);
    check("R4 irq reset", irq, 0);

    wr(1, 8'hFF); rd(1, v); check("R1 mask implemented fields", v, impl_bits());
    wr(1, 8'h00);

    good(8'hA5); good(8'h3C);
    check("R5 two chars delivered", got_cnt, 2);
    check("R5 data", got_data, 8'h3C);
    rd(0, v); check("R9 no close before max", v, 0);
    good(8'h81);
    check("R5 third data", got_data, 8'h81);
    rd(0, v); check("R9 close at max", v, fld(7));
    wr(0, 8'h00); rd(0, v); check("R2 zero write no effect", v, fld(7));
    wr(0, fld(7)); rd(0, v); check("R2 one clears", v, 0);

    close_pulse(); rd(0, v); check("R9 empty close ignored", v, 0);
    good(8'h42); close_pulse(); rd(0, v); check("R9 strobe close", v, fld(7));
    wr(0, fld(7));

    @(negedge clk); tx_done = 1; @(negedge clk); tx_done = 0;
    rd(0, v); check("R10 tx done", v, fld(6));
    wr(1, fld(6)); clocks(1); check("R3 irq unmasked", irq, 1);
    wr(1, 8'h00); clocks(1); check("R3 irq masked", irq, 0);
    wr(1, fld(7)); clocks(1); check("R3 other mask", irq, 0);
    @(negedge clk); reg_wr = 1; reg_sel = 0; reg_wdata = fld(6); tx_done = 1;
    @(negedge clk); reg_wr = 0; tx_done = 0;
    rd(0, v); check("R2 set beats clear", v, fld(6));
    wr(0, fld(6)); rd(0, v); check("R2 cleared", v, 0);
    wr(1, 8'h00);

    base = got_cnt;
    frame(8'h00, 1'b0); clocks(96);
    rd(0, v); check("R6 break set", v, fld(3));
    wr(0, fld(3)); clocks(384);
    rd(0, v); check("R6 long break once", v, 0);
    rxd = 1; clocks(16);
    rd(0, v); check("R7 half bit no end", v, 0);
    clocks(48);
    rd(0, v); check("R7 break end", v, fld(1));
    check("R6 break not delivered", got_cnt, base);
    wr(0, fld(1));

    frame(8'h5A, 1'b0); rxd = 1; clocks(64);
    check("R11 framing not delivered", got_cnt, base);
    rd(0, v); check("R11 no event", v, 0);

    max_cnt = 8'd0;
    @(negedge clk); buf_ready = 0;
    good(8'h33); good(8'h44);
    check("R8 dropped", got_cnt, base);
    rd(0, v); check("R8 busy set", v, fld(5));
    wr(0, fld(5)); good(8'h55);
    rd(0, v); check("R8 busy only first", v, 0);
    @(negedge clk); buf_ready = 1;
    good(8'h66);
    check("R8 resume", got_data, 8'h66);
    close_pulse(); wr(0, 8'hFF);

    fill = 0; maxc = 2 + int'($urandom % 3); max_cnt = 8'(maxc);
    for (int k = 0; k < 16; k++) begin
      d = 8'($urandom); if (d == 0) d = 8'h01;
      good(d); fill++;
      check("R5 random data", got_data, d);
      rd(0, v);
      check("R9 random close", v, closes(fill, maxc) ? fld(7) : 8'h00);
      if (closes(fill, maxc)) begin fill = 0; wr(0, fld(7)); end
    end
    summary();
  end
endmodule